// File: doc/BRIEF.md
# Indirect Memory and Peripheral Access Window

This block gives a host register interface an indirect path into two internal resources that are not directly mapped: a dword-wide SRAM and a small bank of peripheral registers. The host loads an address register and then moves data through a data register. Memory data accesses step their own address by one dword after each access, so a block of words can be streamed with one address load. Peripheral accesses carry a byte-count field in the address word, and their addresses never move.

The window also takes queue write-pointer updates. Each update names a queue and an index, and the block stores one index per queue. A separate debug port reads the stored index of any queue back at any time. Every access is allowed only while the `access_ok` input from the wake controller is high. With `access_ok` low, writes are thrown away and reads return all ones.

Top module: `indirect_window`

## Requirements
- R1: After reset, rd_valid is low. Both memory indices, both peripheral address words, every SRAM word, every peripheral register and every queue pointer read as zero.
- R2: A write to MEM_WADDR (reg_sel 1) loads the low log2(MEM_DEPTH) bits of the data as the memory write index. A write to MEM_WDATA (reg_sel 2) stores the data at that index, and the index then advances by one, wrapping modulo MEM_DEPTH.
- R3: A write to MEM_RADDR (reg_sel 0) loads the memory read index. A read of MEM_RDATA (reg_sel 3) returns the word at that index, and the index then advances by one, wrapping modulo MEM_DEPTH. The read index and the write index are separate.
- R4: Reading MEM_RADDR or MEM_WADDR returns the current index, zero-extended. Reading either write-only data register (reg_sel 2 or 6), QUEUE_WPTR (reg_sel 8), or an unused select (9 to 15) returns zero. Writes to reg_sel 3, 7 or 9 to 15 change nothing.
- R5: A peripheral address word holds the register offset in bits 15:0 and the byte count minus one in bits 25:24. PER_WADDR is reg_sel 4 and PER_RADDR is reg_sel 5. The target register is the offset modulo PER_REGS. Reading an address register returns the offset and the size in those same bit positions, with all other bits zero. Peripheral data accesses never change either address word.
- R6: A write to PER_WDATA (reg_sel 6) updates only the low (size+1) bytes of the target register, using the size in the write address word. The upper bytes keep their value.
- R7: A read of PER_RDATA (reg_sel 7) returns the low (size+1) bytes of the target register, using the size in the read address word. The upper bytes read as zero.
- R8: A write to QUEUE_WPTR (reg_sel 8) stores bits 7:0 as the write index of the queue chosen by bits 11:8. dbg_q_ptr shows the stored index of queue dbg_q_sel combinationally, one cycle after the write.
- R9: While access_ok is low, writes are dropped and no index, address word, memory word, peripheral register or queue pointer changes. A read while access_ok is low returns 0xFFFFFFFF.
- R10: For a read, rd_valid and reg_rdata are presented the cycle after reg_rd is sampled. If reg_wr and reg_rd are both high in a cycle, only the write is performed and rd_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| access_ok | input | 1 | High while the internal domain is awake and access is granted |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 4 | Register select (encoding in R2 to R8) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data present this cycle |
| dbg_q_sel | input | $clog2(NUM_Q) | Queue chosen for the debug read |
| dbg_q_ptr | output | 8 | Stored write index of the chosen queue |

## Verification
A corrupt memory index shows up on the next MEM_RDATA read. The word comes back from the wrong location, and reading the index register back shows the offset directly. A mistake in the peripheral byte mask shows on the next PER_RDATA read as upper bytes that were lost or changed. A wrong queue pointer is visible on dbg_q_ptr the cycle after the update. A broken access gate shows as a read that does not return all ones, or as state that moved while access_ok was low, which later reads expose. The bench keeps a behavioural model of all of this state and compares the read port and the debug port on every clock. It mixes directed cases for wrap, partial sizes and the gate with a long random run.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

    typedef enum logic [3:0] {
        SEL_MEM_RADDR = 4'd0,
        SEL_MEM_WADDR = 4'd1,
        SEL_MEM_WDATA = 4'd2,
        SEL_MEM_RDATA = 4'd3,
        SEL_PER_WADDR = 4'd4,
        SEL_PER_RADDR = 4'd5,
        SEL_PER_WDATA = 4'd6,
        SEL_PER_RDATA = 4'd7,
        SEL_QUEUE_WP  = 4'd8
    } win_sel_e;

    localparam int PER_OFF_W   = 16;
    localparam int PER_SZ_LSB  = 24;
    localparam int Q_IDX_W     = 8;
    localparam int Q_SEL_LSB   = 8;

    // Bytes-minus-one code to a mask over the low bytes of a dword.
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            2'd2:    size_mask = 32'h00FF_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/iwin_mem.sv
module iwin_mem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_waddr,
    input  logic          ld_raddr,
    input  logic [AW-1:0] addr_in,
    input  logic          wr_data,
    input  logic          rd_data,
    input  logic [31:0]   wdata,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    typedef struct packed {
        logic [AW-1:0] waddr;
        logic [AW-1:0] raddr;
    } mem_st_t;

    mem_st_t     st_d, st_q;
    logic [31:0] mem_d [DEPTH];
    logic [31:0] mem_q [DEPTH];

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (ld_waddr) st_d.waddr = addr_in;
        if (ld_raddr) st_d.raddr = addr_in;
        if (wr_data) begin
            mem_d[st_q.waddr] = wdata;
            st_d.waddr        = st_q.waddr + AW'(1);
        end
        if (rd_data) st_d.raddr = st_q.raddr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign waddr = st_q.waddr;
    assign raddr = st_q.raddr;
    assign rdata = mem_q[st_q.raddr];

    p_waddr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> waddr == $past(waddr) + AW'(1));
    p_word_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> mem_q[$past(waddr)] == $past(wdata));
    p_raddr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data |=> raddr == $past(raddr) + AW'(1));

endmodule

// File: rtl/iwin_per.sv
module iwin_per
    import iwin_pkg::*;
#(
    parameter int NREG = 16,
    parameter int PW   = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_waddr,
    input  logic                 ld_raddr,
    input  logic [PER_OFF_W-1:0] off_in,
    input  logic [1:0]           sz_in,
    input  logic                 wr_data,
    input  logic [31:0]          wdata,
    output logic [31:0]          waddr_word,
    output logic [31:0]          raddr_word,
    output logic [31:0]          rdata
);

    typedef struct packed {
        logic [PER_OFF_W-1:0] w_off;
        logic [1:0]           w_sz;
        logic [PER_OFF_W-1:0] r_off;
        logic [1:0]           r_sz;
    } per_st_t;

    per_st_t     st_d, st_q;
    logic [31:0] regs_d [NREG];
    logic [31:0] regs_q [NREG];
    logic [PW-1:0] w_idx, r_idx;
    logic [31:0]   w_mask;

    assign w_idx  = st_q.w_off[PW-1:0];
    assign r_idx  = st_q.r_off[PW-1:0];
    assign w_mask = size_mask(st_q.w_sz);

    always_comb begin
        st_d   = st_q;
        regs_d = regs_q;
        if (ld_waddr) begin
            st_d.w_off = off_in;
            st_d.w_sz  = sz_in;
        end
        if (ld_raddr) begin
            st_d.r_off = off_in;
            st_d.r_sz  = sz_in;
        end
        if (wr_data) regs_d[w_idx] = (regs_q[w_idx] & ~w_mask) | (wdata & w_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            st_q   <= st_d;
            regs_q <= regs_d;
        end
    end

    assign waddr_word = {6'd0, st_q.w_sz, 8'd0, st_q.w_off};
    assign raddr_word = {6'd0, st_q.r_sz, 8'd0, st_q.r_off};
    assign rdata      = regs_q[r_idx] & size_mask(st_q.r_sz);

    p_addr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> $stable(waddr_word) && $stable(raddr_word));
    p_keep_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (regs_q[$past(w_idx)] & ~$past(w_mask))
                    == ($past(regs_q[w_idx]) & ~$past(w_mask)));

endmodule

// File: rtl/iwin_qptr.sv
module iwin_qptr
    import iwin_pkg::*;
#(
    parameter int NQ = 16,
    parameter int QW = $clog2(NQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [QW-1:0]      wsel,
    input  logic [Q_IDX_W-1:0] widx,
    input  logic [QW-1:0]      dbg_sel,
    output logic [Q_IDX_W-1:0] dbg_ptr
);

    logic [Q_IDX_W-1:0] ptr_d [NQ];
    logic [Q_IDX_W-1:0] ptr_q [NQ];

    always_comb begin
        ptr_d = ptr_q;
        if (wr) ptr_d[wsel] = widx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) ptr_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign dbg_ptr = ptr_q[dbg_sel];

    p_ptr_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ptr_q[$past(wsel)] == $past(widx));

endmodule

// File: rtl/indirect_window.sv
module indirect_window
    import iwin_pkg::*;
#(
    parameter int MEM_DEPTH = 64,
    parameter int PER_REGS  = 16,
    parameter int NUM_Q     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     access_ok,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [3:0]               reg_sel,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     rd_valid,
    input  logic [$clog2(NUM_Q)-1:0] dbg_q_sel,
    output logic [7:0]               dbg_q_ptr
);

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int QW = $clog2(NUM_Q);

    typedef struct packed {
        logic        rv;
        logic [31:0] rdata;
    } rd_st_t;

    win_sel_e    sel;
    logic        wr_go, rd_req, rd_go;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [31:0] mem_rdata, per_wword, per_rword, per_rdata;
    rd_st_t      rd_d, rd_q;

    assign sel    = win_sel_e'(reg_sel);
    assign wr_go  = reg_wr & access_ok;
    assign rd_req = reg_rd & ~reg_wr;
    assign rd_go  = rd_req & access_ok;

    iwin_mem #(.DEPTH(MEM_DEPTH)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_waddr (wr_go && sel == SEL_MEM_WADDR),
        .ld_raddr (wr_go && sel == SEL_MEM_RADDR),
        .addr_in  (reg_wdata[AW-1:0]),
        .wr_data  (wr_go && sel == SEL_MEM_WDATA),
        .rd_data  (rd_go && sel == SEL_MEM_RDATA),
        .wdata    (reg_wdata),
        .waddr    (mem_waddr),
        .raddr    (mem_raddr),
        .rdata    (mem_rdata)
    );

    iwin_per #(.NREG(PER_REGS)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_waddr   (wr_go && sel == SEL_PER_WADDR),
        .ld_raddr   (wr_go && sel == SEL_PER_RADDR),
        .off_in     (reg_wdata[PER_OFF_W-1:0]),
        .sz_in      (reg_wdata[PER_SZ_LSB +: 2]),
        .wr_data    (wr_go && sel == SEL_PER_WDATA),
        .wdata      (reg_wdata),
        .waddr_word (per_wword),
        .raddr_word (per_rword),
        .rdata      (per_rdata)
    );

    iwin_qptr #(.NQ(NUM_Q)) u_qptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_go && sel == SEL_QUEUE_WP),
        .wsel    (reg_wdata[Q_SEL_LSB +: QW]),
        .widx    (reg_wdata[Q_IDX_W-1:0]),
        .dbg_sel (dbg_q_sel),
        .dbg_ptr (dbg_q_ptr)
    );

    always_comb begin
        rd_d.rv    = rd_req;
        rd_d.rdata = '0;
        if (rd_req && !access_ok) begin
            rd_d.rdata = 32'hFFFF_FFFF;
        end else if (rd_go) begin
            case (sel)
                SEL_MEM_RADDR: rd_d.rdata = 32'(mem_raddr);
                SEL_MEM_WADDR: rd_d.rdata = 32'(mem_waddr);
                SEL_MEM_RDATA: rd_d.rdata = mem_rdata;
                SEL_PER_WADDR: rd_d.rdata = per_wword;
                SEL_PER_RADDR: rd_d.rdata = per_rword;
                SEL_PER_RDATA: rd_d.rdata = per_rdata;
                default:       rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid  = rd_q.rv;
    assign reg_rdata = rd_q.rdata;

    p_locked_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && !access_ok) |=> rd_valid && reg_rdata == 32'hFFFF_FFFF);
    p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ok |=> $stable(mem_waddr) && $stable(mem_raddr)
                       && $stable(per_wword) && $stable(per_rword));
    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr) |=> rd_valid);
    p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !rd_valid);

endmodule

// File: tb/indirect_window_test.sv
`timescale 1ns/1ps
module indirect_window_test;

    localparam int DEPTH = 64;
    localparam int NREG  = 16;
    localparam int NQ    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        access_ok = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_valid;
    logic [3:0]  dbg_q_sel = '0;
    logic [7:0]  dbg_q_ptr;

    int checks = 0, failures = 0, cyc = 0;

    indirect_window uut (
        .clk(clk), .rst_n(rst_n), .access_ok(access_ok),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_valid(rd_valid),
        .dbg_q_sel(dbg_q_sel), .dbg_q_ptr(dbg_q_ptr)
    );

    always #2 clk = ~clk;

    // Behavioural reference state
    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_per [NREG];
    logic [7:0]  m_q   [NQ];
    int          m_wa, m_ra;
    logic [15:0] m_pwo, m_pro;
    logic [1:0]  m_pws, m_prs;
    logic        e_rv;
    logic [31:0] e_rd;
    string       e_tag;

    function automatic logic [31:0] bmask(input logic [1:0] s);
        logic [31:0] m = '0;
        for (int b = 0; b <= int'(s); b++) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
            for (int i = 0; i < NREG; i++)  m_per[i] = '0;
            for (int i = 0; i < NQ; i++)    m_q[i]   = '0;
            m_wa = 0; m_ra = 0; m_pwo = '0; m_pro = '0; m_pws = '0; m_prs = '0;
            e_rv = 1'b0; e_rd = '0; e_tag = "R1";
        end else begin
            e_rv = 1'b0;
            if (reg_wr) begin
                if (access_ok) begin
                    case (reg_sel)
                        4'd0: m_ra = int'(reg_wdata) & (DEPTH-1);
                        4'd1: m_wa = int'(reg_wdata) & (DEPTH-1);
                        4'd2: begin m_mem[m_wa] = reg_wdata; m_wa = (m_wa + 1) % DEPTH; end
                        4'd4: begin m_pwo = reg_wdata[15:0]; m_pws = reg_wdata[25:24]; end
                        4'd5: begin m_pro = reg_wdata[15:0]; m_prs = reg_wdata[25:24]; end
                        4'd6: m_per[m_pwo % NREG] = (m_per[m_pwo % NREG] & ~bmask(m_pws))
                                                    | (reg_wdata & bmask(m_pws));
                        4'd8: m_q[reg_wdata[11:8]] = reg_wdata[7:0];
                        default: ;
                    endcase
                end
            end else if (reg_rd) begin
                e_rv = 1'b1;
                if (!access_ok) begin
                    e_rd = 32'hFFFF_FFFF; e_tag = "R9";
                end else begin
                    case (reg_sel)
                        4'd0: begin e_rd = 32'(m_ra); e_tag = "R4"; end
                        4'd1: begin e_rd = 32'(m_wa); e_tag = "R4"; end
                        4'd3: begin e_rd = m_mem[m_ra]; m_ra = (m_ra + 1) % DEPTH; e_tag = "R3"; end
                        4'd4: begin e_rd = {6'd0, m_pws, 8'd0, m_pwo}; e_tag = "R5"; end
                        4'd5: begin e_rd = {6'd0, m_prs, 8'd0, m_pro}; e_tag = "R5"; end
                        4'd7: begin e_rd = m_per[m_pro % NREG] & bmask(m_prs); e_tag = "R7"; end
                        default: begin e_rd = '0; e_tag = "R4"; end
                    endcase
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cyc > 1) begin
            chk("R10 rd_valid", 32'(rd_valid), 32'(e_rv));
            if (e_rv) chk(e_tag, reg_rdata, e_rd);
            chk("R8 dbg_q_ptr", 32'(dbg_q_ptr), 32'(m_q[dbg_q_sel]));
        end
    end

    always @(posedge clk) begin
        if (cyc > 60000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<60000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input logic w, input logic r, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = w; reg_rd = r; reg_sel = s; reg_wdata = d;
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d); step(1'b1, 1'b0, s, d); endtask
    task automatic rd(input logic [3:0] s);                       step(1'b0, 1'b1, s, '0); endtask
    task automatic idle();                                         step(1'b0, 1'b0, '0, '0); endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state through the ports
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        for (int q = 0; q < NQ; q++) begin
            dbg_q_sel = 4'(q); #1;
            chk("R1 queue ptr", 32'(dbg_q_ptr), 32'd0);
        end
        for (int s = 0; s < 10; s++) rd(4'(s));
        // R2: streaming writes with wrap
        wr(4'd1, 32'd62);
        wr(4'd2, 32'hA0A0_0001); wr(4'd2, 32'hA0A0_0002); wr(4'd2, 32'hA0A0_0003);
        rd(4'd1);
        // R3: separate read index, wrap
        wr(4'd0, 32'd62);
        rd(4'd3); rd(4'd3); rd(4'd3); rd(4'd0);
        wr(4'd0, 32'h0000_0100); rd(4'd0); rd(4'd3);
        // R4: write-only/unused reads and ignored writes
        wr(4'd3, 32'h1234_5678); wr(4'd7, 32'h1); wr(4'd12, 32'h2);
        rd(4'd2); rd(4'd6); rd(4'd8); rd(4'd15); rd(4'd1);
        // R5/R6/R7: peripheral sizes
        wr(4'd4, 32'h0300_0013);            // offset 0x13 -> reg 3, full dword
        wr(4'd6, 32'hDEAD_BEEF); wr(4'd6, 32'hDEAD_BEEF); rd(4'd4);
        wr(4'd4, 32'h0000_0003);            // one byte
        wr(4'd6, 32'h1111_1155);
        wr(4'd4, 32'h0100_0003);            // two bytes
        wr(4'd6, 32'h2222_6677); rd(4'd4);
        wr(4'd5, 32'h0300_0003); rd(4'd7); rd(4'd7); rd(4'd5);
        wr(4'd5, 32'h0200_0003); rd(4'd7);
        wr(4'd5, 32'h0000_0003); rd(4'd7);
        // R8: queue pointers
        wr(4'd8, 32'h0000_0A5C); dbg_q_sel = 4'd10;
        wr(4'd8, 32'h0000_0F01); idle(); dbg_q_sel = 4'd15; idle();
        // R9: gate closed
        access_ok = 1'b0;
        wr(4'd1, 32'd5); wr(4'd2, 32'h5555_5555); wr(4'd8, 32'h0000_0AFF);
        wr(4'd6, 32'h0); rd(4'd3); rd(4'd1); rd(4'd9);
        idle(); access_ok = 1'b1;
        dbg_q_sel = 4'd10; rd(4'd1); rd(4'd0); rd(4'd7); rd(4'd4);
        // R10: simultaneous write and read
        step(1'b1, 1'b1, 4'd1, 32'd7); rd(4'd1);
        // Random mix
        void'($urandom(32'd77));
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] s = 4'($urandom_range(0, 9));
            logic [31:0] d = $urandom;
            access_ok = ($urandom_range(0, 9) != 0);
            dbg_q_sel = 4'($urandom_range(0, 15));
            case ($urandom_range(0, 3))
                0:       wr(s, d);
                1:       step(1'b1, 1'b1, s, d);
                2:       idle();
                default: rd(s);
            endcase
        end
        access_ok = 1'b1;
        idle(); idle(); idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule